// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Edge Interrupts

This block is an eight-pin general-purpose I/O port. Software reaches it through a small synchronous register bus. Through that bus it sets the direction of each pin, sets an output-data byte, reads the sampled pin levels, chooses which edge raises an interrupt on each pin, and acknowledges and enables those interrupts. On a pin set as an input, the output-data bit switches that pin's weak pull-up on or off instead of setting a level.

A per-pin select input hands a pin to an alternate peripheral, such as a PWM generator. While a pin is handed over, the peripheral's own value and enable reach the pad, and the port's registers have no say in what the pin drives. Sampling and edge interrupts keep running on every pin whatever its current role. Pad inputs cross into the clock domain through a two-flop synchronizer. Edges are found by comparing the synchronized level with its value one cycle earlier.

Top module: `gpio8_port`

## Requirements
- R1: After reset these registers read: direction 0x00, output data 0xFF, edge select 0x00, flags 0x00, enables 0x00. The input register reads 0xFF. Every pad has `pad_oe`=0 and `pad_pu`=1, and `irq`=0.
- R2: A GPIO pin with direction bit 1 has `pad_oe`=1 and `pad_out` equal to its output-data bit.
- R3: A GPIO pin with direction bit 0 has `pad_oe`=0 and `pad_pu` equal to its output-data bit. `pad_pu` and `pad_oe` are never both 1 on one pin.
- R4: Writing the direction register leaves the output-data register unchanged.
- R5: The input register (address 2) holds each pad level after two clock edges of synchronization. This includes pins serving an alternate function. Writes to address 2 are ignored.
- R6: With `alt_sel[n]`=1, `pad_out[n]`=`alt_out[n]`, `pad_oe[n]`=`alt_oe[n]` and `pad_pu[n]`=0. The output-data register has no effect on that pin.
- R7: Edge-select bit 0 flags a rising edge and bit 1 flags a falling edge. The flag bit reads 1 after the third clock edge following the pad change. This applies to alternate-function pins too.
- R8: Writing 1 to a flag bit (address 4) clears it. Writing 0 has no effect. A new edge in the same cycle as a clear leaves the flag set.
- R9: `irq` is the OR over all pins of each flag ANDed with its enable bit (address 5).
- R10: Changing only the edge-select register never sets a flag.
- R11: Register map: 0 direction, 1 output data, 2 input, 3 edge select, 4 flags, 5 enables. Addresses 6 and 7 read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 3 | Register address |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` (combinational) |
| pad_in | input | 8 | Pad input levels (asynchronous) |
| pad_out | output | 8 | Pad output value |
| pad_oe | output | 8 | Pad output enable |
| pad_pu | output | 8 | Weak pull-up enable |
| alt_sel | input | 8 | Per-pin alternate-function select |
| alt_out | input | 8 | Alternate-function output value |
| alt_oe | input | 8 | Alternate-function output enable |
| irq_flags | output | 8 | Sticky edge flags |
| irq_en | output | 8 | Interrupt enable bits |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that the bus is sampled only at rising clock edges, that `bus_addr` and `bus_we` are known outside reset, and that reset is held for at least two clock edges, so the two-cycle history behind the flag-cause check starts from reset values. The bench changes every input on the falling edge. It holds `pad_in` at 0xFF during reset to match the synchronizer's reset value. It lets the pads settle and clears the flags before each interrupt scenario, so every flag that appears traces back to one pad change the bench made on purpose.

// File: rtl/gpio8_pkg.sv
package gpio8_pkg;
    localparam int unsigned GPIO_W = 8;
    localparam int unsigned ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        A_DIR   = 3'd0,
        A_DOUT  = 3'd1,
        A_DIN   = 3'd2,
        A_ESEL  = 3'd3,
        A_FLAG  = 3'd4,
        A_IEN   = 3'd5
    } reg_addr_e;

    typedef struct packed {
        logic [GPIO_W-1:0] dir;
        logic [GPIO_W-1:0] dout;
        logic [GPIO_W-1:0] esel;
        logic [GPIO_W-1:0] ien;
    } ctrl_regs_t;

    localparam ctrl_regs_t CTRL_RST = '{
        dir:  '0,
        dout: '1,
        esel: '0,
        ien:  '0
    };
endpackage

// File: rtl/gpio8_sync.sv
module gpio8_sync #(
    parameter int unsigned          W       = 8,
    parameter int unsigned          STAGES  = 2,
    parameter logic [W-1:0]         RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [STAGES-1:0][W-1:0] stage_d, stage_q;

    always_comb begin
        stage_d[0] = async_in;
        for (int s = 1; s < STAGES; s++) begin
            stage_d[s] = stage_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) begin
                stage_q[s] <= RST_VAL;
            end
        end else begin
            stage_q <= stage_d;
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio8_edge_irq.sv
module gpio8_edge_irq #(
    parameter int unsigned  W       = 8,
    parameter logic [W-1:0] RST_VAL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] edge_sel,
    input  logic [W-1:0] clr_mask,
    input  logic [W-1:0] en,
    output logic [W-1:0] flags,
    output logic         req
);
    typedef struct packed {
        logic [W-1:0] prev;
        logic [W-1:0] flag;
    } edge_state_t;

    edge_state_t st_d, st_q;
    logic [W-1:0] hit;

    // per-pin edge qualification: polarity chooses which transition counts
    for (genvar i = 0; i < W; i++) begin : g_pin
        always_comb begin
            if (edge_sel[i]) hit[i] = st_q.prev[i] & ~lvl[i];
            else             hit[i] = ~st_q.prev[i] & lvl[i];
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.prev = lvl;
        // set has priority over a same-cycle clear
        st_d.flag = (st_q.flag & ~clr_mask) | hit;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.prev <= RST_VAL;
            st_q.flag <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags = st_q.flag;
    assign req   = |(st_q.flag & en);
endmodule

// File: rtl/gpio8_pad_mux.sv
module gpio8_pad_mux #(
    parameter int unsigned W = 8
) (
    input  logic [W-1:0] dir,
    input  logic [W-1:0] dout,
    input  logic [W-1:0] alt_sel,
    input  logic [W-1:0] alt_out,
    input  logic [W-1:0] alt_oe,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] pad_pu
);
    for (genvar i = 0; i < W; i++) begin : g_pin
        always_comb begin
            if (alt_sel[i]) begin
                pad_out[i] = alt_out[i];
                pad_oe[i]  = alt_oe[i];
                pad_pu[i]  = 1'b0;
            end else if (dir[i]) begin
                pad_out[i] = dout[i];
                pad_oe[i]  = 1'b1;
                pad_pu[i]  = 1'b0;
            end else begin
                pad_out[i] = 1'b0;
                pad_oe[i]  = 1'b0;
                pad_pu[i]  = dout[i];
            end
        end
    end
endmodule

// File: rtl/gpio8_port.sv
module gpio8_port
    import gpio8_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [GPIO_W-1:0] bus_wdata,
    output logic [GPIO_W-1:0] bus_rdata,
    input  logic [GPIO_W-1:0] pad_in,
    output logic [GPIO_W-1:0] pad_out,
    output logic [GPIO_W-1:0] pad_oe,
    output logic [GPIO_W-1:0] pad_pu,
    input  logic [GPIO_W-1:0] alt_sel,
    input  logic [GPIO_W-1:0] alt_out,
    input  logic [GPIO_W-1:0] alt_oe,
    output logic [GPIO_W-1:0] irq_flags,
    output logic [GPIO_W-1:0] irq_en,
    output logic              irq
);
    localparam logic [GPIO_W-1:0] PAD_IDLE = '1;

    ctrl_regs_t        regs_d, regs_q;
    logic [GPIO_W-1:0] in_lvl;
    logic [GPIO_W-1:0] flag_clr;
    logic [GPIO_W-1:0] dout_now;

    gpio8_sync #(
        .W       (GPIO_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (PAD_IDLE)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pad_in),
        .sync_out (in_lvl)
    );

    // register next-state and write decode
    always_comb begin
        regs_d   = regs_q;
        flag_clr = '0;
        if (bus_we) begin
            case (bus_addr)
                A_DIR:   regs_d.dir  = bus_wdata;
                A_DOUT:  regs_d.dout = bus_wdata;
                A_ESEL:  regs_d.esel = bus_wdata;
                A_FLAG:  flag_clr    = bus_wdata;
                A_IEN:   regs_d.ien  = bus_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= CTRL_RST;
        else        regs_q <= regs_d;
    end

    gpio8_edge_irq #(
        .W       (GPIO_W),
        .RST_VAL (PAD_IDLE)
    ) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (in_lvl),
        .edge_sel (regs_q.esel),
        .clr_mask (flag_clr),
        .en       (regs_q.ien),
        .flags    (irq_flags),
        .req      (irq)
    );

    gpio8_pad_mux #(
        .W (GPIO_W)
    ) u_mux (
        .dir     (regs_q.dir),
        .dout    (regs_q.dout),
        .alt_sel (alt_sel),
        .alt_out (alt_out),
        .alt_oe  (alt_oe),
        .pad_out (pad_out),
        .pad_oe  (pad_oe),
        .pad_pu  (pad_pu)
    );

    // read mux
    always_comb begin
        case (bus_addr)
            A_DIR:   bus_rdata = regs_q.dir;
            A_DOUT:  bus_rdata = regs_q.dout;
            A_DIN:   bus_rdata = in_lvl;
            A_ESEL:  bus_rdata = regs_q.esel;
            A_FLAG:  bus_rdata = irq_flags;
            A_IEN:   bus_rdata = regs_q.ien;
            default: bus_rdata = '0;
        endcase
    end

    assign irq_en   = regs_q.ien;
    assign dout_now = regs_q.dout;
endmodule

// File: rtl/gpio8_port_chk.sv
module gpio8_port_chk
    import gpio8_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [GPIO_W-1:0] bus_wdata,
    input  logic [GPIO_W-1:0] pad_out,
    input  logic [GPIO_W-1:0] pad_oe,
    input  logic [GPIO_W-1:0] pad_pu,
    input  logic [GPIO_W-1:0] alt_sel,
    input  logic [GPIO_W-1:0] alt_out,
    input  logic [GPIO_W-1:0] alt_oe,
    input  logic [GPIO_W-1:0] irq_flags,
    input  logic [GPIO_W-1:0] irq_en,
    input  logic              irq,
    input  logic [GPIO_W-1:0] dout_now,
    input  logic [GPIO_W-1:0] in_lvl
);
    logic dir_wr;
    logic flag_wr;
    assign dir_wr  = bus_we && (bus_addr == A_DIR);
    assign flag_wr = bus_we && (bus_addr == A_FLAG);

    // R3: pull-up never on while the pad is driven
    p_pad_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

    // R6: a handed-over pin follows the peripheral only
    p_alt_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (((pad_out ^ alt_out) | (pad_oe ^ alt_oe) | pad_pu) & alt_sel) == '0);

    // R4: direction writes leave output data alone
    p_dir_keeps_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dir_wr |=> $stable(dout_now));

    // R8: a flag only drops when a 1 was written to it
    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((($past(irq_flags) & ~($past(flag_wr) ? $past(bus_wdata) : '0))
                   & ~irq_flags) == '0));

    // R9: a request only appears with an enabled flag
    p_irq_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ((irq_flags & irq_en) != '0));

    // R10 / R7: a new flag needs a change of the synchronized level
    p_flag_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (((irq_flags & ~$past(irq_flags))
                   & ~($past(in_lvl, 1) ^ $past(in_lvl, 2))) == '0));
endmodule

bind gpio8_port gpio8_port_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .pad_out   (pad_out),
    .pad_oe    (pad_oe),
    .pad_pu    (pad_pu),
    .alt_sel   (alt_sel),
    .alt_out   (alt_out),
    .alt_oe    (alt_oe),
    .irq_flags (irq_flags),
    .irq_en    (irq_en),
    .irq       (irq),
    .dout_now  (dout_now),
    .in_lvl    (in_lvl)
);

// File: tb/gpio8_port_tb.sv
`timescale 1ns/1ps
module gpio8_port_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pad_in = 8'hFF;
    logic [7:0] pad_out, pad_oe, pad_pu;
    logic [7:0] alt_sel = '0, alt_out = '0, alt_oe = '0;
    logic [7:0] irq_flags, irq_en;
    logic       irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    gpio8_port u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu),
        .alt_sel(alt_sel), .alt_out(alt_out), .alt_oe(alt_oe),
        .irq_flags(irq_flags), .irq_en(irq_en), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic cycles(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        rd(3'd0, v); chk("R1 dir", v, 8'h00);
        rd(3'd1, v); chk("R1 dout", v, 8'hFF);
        rd(3'd3, v); chk("R1 esel", v, 8'h00);
        rd(3'd4, v); chk("R1 flags", v, 8'h00);
        rd(3'd5, v); chk("R1 ien", v, 8'h00);
        rd(3'd2, v); chk("R1 din", v, 8'hFF);
        chk("R1 pad_oe", pad_oe, 8'h00);
        chk("R1 pad_pu", pad_pu, 8'hFF);
        chk("R1 irq", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_gpio_out;
        wr(3'd1, 8'hA5);
        wr(3'd0, 8'h0F);
        #1;
        chk("R2 pad_oe", pad_oe, 8'h0F);
        chk("R2 pad_out", pad_out & 8'h0F, 8'h05);
        chk("R3 pad_pu", pad_pu, 8'hA0);
    endtask

    task automatic t_dir_keeps_out;
        logic [7:0] v;
        wr(3'd0, 8'hF0);
        rd(3'd1, v); chk("R4 dout kept", v, 8'hA5);
        chk("R3 pad_pu after dir", pad_pu, 8'h05);
    endtask

    task automatic t_input;
        logic [7:0] v;
        @(negedge clk); pad_in = 8'h3C;
        @(posedge clk); #1; bus_addr = 3'd2; #1;
        chk("R5 din after 1 edge", bus_rdata, 8'hFF);
        @(posedge clk); #1;
        chk("R5 din after 2 edges", bus_rdata, 8'h3C);
        wr(3'd2, 8'h00);
        rd(3'd2, v); chk("R5 write ignored", v, 8'h3C);
    endtask

    task automatic t_alt;
        logic [7:0] v;
        wr(3'd4, 8'hFF);
        @(negedge clk);
        alt_sel = 8'h81; alt_out = 8'h01; alt_oe = 8'h81;
        #1;
        chk("R6 pad_oe", pad_oe, 8'hF1);
        chk("R6 pad_out", pad_out & 8'h81, 8'h01);
        chk("R6 pad_pu", pad_pu, 8'h04);
        wr(3'd1, 8'h5A);
        chk("R6 dout no effect", pad_out & 8'h81, 8'h01);
        // alternate pins still sampled and still raise flags
        @(negedge clk); pad_in = 8'hBD;
        cycles(3);
        rd(3'd2, v); chk("R5 din on alt pins", v, 8'hBD);
        chk("R7 flag on alt pins", irq_flags, 8'h81);
        @(negedge clk); alt_sel = '0; alt_out = '0; alt_oe = '0;
        wr(3'd1, 8'hA5);
    endtask

    task automatic t_edges;
        wr(3'd0, 8'h00);
        @(negedge clk); pad_in = 8'h00;
        cycles(4);
        wr(3'd4, 8'hFF);
        wr(3'd3, 8'h00);
        wr(3'd5, 8'h01);
        @(negedge clk); pad_in = 8'h03;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R7 no flag before 3rd edge", irq_flags, 8'h00);
        @(posedge clk); @(negedge clk);
        chk("R7 rising flags", irq_flags, 8'h03);
        chk("R9 irq enabled", {7'd0, irq}, 8'h01);
        wr(3'd5, 8'h00);
        chk("R9 irq masked", {7'd0, irq}, 8'h00);
        wr(3'd4, 8'h01);
        chk("R8 w1c bit0", irq_flags, 8'h02);
        wr(3'd4, 8'h00);
        chk("R8 write 0 no effect", irq_flags, 8'h02);
        wr(3'd5, 8'h02);
        chk("R9 irq via bit1", {7'd0, irq}, 8'h01);
        wr(3'd5, 8'h00);
        wr(3'd4, 8'hFF);
        wr(3'd3, 8'h02);
        @(negedge clk); pad_in = 8'h00;
        cycles(3);
        chk("R7 falling select", irq_flags, 8'h02);
        wr(3'd4, 8'hFF);
    endtask

    task automatic t_collision;
        wr(3'd3, 8'h00);
        @(negedge clk); pad_in = 8'h04;
        cycles(3);
        chk("R7 setup bit2", irq_flags, 8'h04);
        wr(3'd3, 8'h04);
        @(negedge clk); pad_in = 8'h00;
        @(posedge clk); @(posedge clk);
        wr(3'd4, 8'h04);       // clear lands on the same edge as the new set
        chk("R8 set wins over clear", irq_flags, 8'h04);
        wr(3'd4, 8'h04);
        chk("R8 later clear", irq_flags, 8'h00);
    endtask

    task automatic t_polarity;
        wr(3'd4, 8'hFF);
        wr(3'd3, 8'hFF);
        wr(3'd3, 8'h00);
        wr(3'd3, 8'hFF);
        cycles(4);
        chk("R10 no spurious flag", irq_flags, 8'h00);
        @(negedge clk); pad_in = 8'hFF;
        cycles(4);
        wr(3'd4, 8'hFF);
        wr(3'd3, 8'h00);
        cycles(4);
        chk("R10 no flag high level", irq_flags, 8'h00);
    endtask

    task automatic t_map;
        logic [7:0] v;
        wr(3'd0, 8'h3C);
        wr(3'd6, 8'hFF);
        wr(3'd7, 8'hFF);
        rd(3'd6, v); chk("R11 addr6 reads 0", v, 8'h00);
        rd(3'd7, v); chk("R11 addr7 reads 0", v, 8'h00);
        rd(3'd0, v); chk("R11 dir untouched", v, 8'h3C);
        rd(3'd1, v); chk("R11 dout untouched", v, 8'hA5);
        rd(3'd5, v); chk("R11 ien untouched", v, 8'h00);
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        t_reset();
        t_gpio_out();
        t_dir_keeps_out();
        t_input();
        t_alt();
        t_edges();
        t_collision();
        t_polarity();
        t_map();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 1'b0, 1'b1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule